// File: doc/BRIEF.md
# Packed Firmware Image Loader

This engine consumes a little-endian firmware container one byte at a time over a valid/ready input and checks it while it streams. It reads a 16-byte file header, then a 28-byte header for each module, then a 16-byte record for each memory block. Every payload byte is turned into one write on a memory port that targets either instruction RAM or data RAM.

Instruction-RAM payloads are shifted up by a parameterised base address. Data-RAM payloads land at their stated offset. For each module whose type code is on an allowed list, the engine emits one info pulse carrying the type, the entry address, the persistent size and the scratch size. A module whose type is not on the list is stepped over in silence.

A controller drives the expected image length on `total_len` and pulses `start`. It then streams the bytes and waits until either `done` goes high or `err_code` becomes non-zero. Any error halts the engine until the next start.

Top module: `fw_image_loader`

## Requirements
- R1: After reset, and in every idle state, `in_ready`, `done`, `wr_en` and `info_valid` are low and `err_code` is 0. A `start` pulse clears `done` and `err_code` and raises `in_ready` on the next cycle.
- R2: The first four image bytes must be 0x24 0x53 0x53 0x54. Any other value sets `err_code` to 1 and issues no write.
- R3: Bytes 4..7 hold the file size as a little-endian word. If `total_len` differs from this file size plus 16, `err_code` becomes 2 and no write is issued.
- R4: A block record holds four little-endian words: type, payload size, RAM offset and a reserved word. For type 1 each write has `wr_sel`=0 and address offset+`IRAM_BASE` (default 0x80000). For type 2 each write has `wr_sel`=1 and the address is the offset itself.
- R5: Each accepted payload byte produces exactly one write on the cycle after it is taken. Writes within a block go to consecutive addresses, and the payload starts right after its record.
- R6: A block type other than 1 or 2 sets `err_code` to 3, and no write is issued for that block.
- R7: A block with payload size 0 sets `err_code` to 4.
- R8: A module header is laid out as follows: signature (4 bytes), module size, block count, a 16-bit type plus 16-bit pad, entry point, persistent size and scratch size, with all words little-endian. For an allowed module, `info_valid` pulses for one cycle. In that cycle `info_type` is the type, `info_entry` is the entry point minus 4, and `info_persist` and `info_scratch` are the two sizes.
- R9: Only type codes whose bit is set in `ALLOW_MASK` are accepted (default: codes 0 to 5). Any other module produces no info pulse and no write, and raises no error.
- R10: The next module header always starts 28 + module-size bytes after the start of the previous one. Bytes left in a module body after its blocks are consumed without effect.
- R11: `done` rises after the last byte of the last module. With a module count of 0 (bytes 8..11), it rises right after the file header.
- R12: Once `err_code` is non-zero it holds its value, `in_ready` stays low, and `done` stays low until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin parsing a new image |
| total_len | input | LEN_W | Total image length in bytes |
| in_valid | input | 1 | Input byte valid |
| in_byte | input | 8 | Input byte |
| in_ready | output | 1 | Engine accepts a byte |
| wr_en | output | 1 | Memory write strobe |
| wr_sel | output | 1 | Target: 0 instruction RAM, 1 data RAM |
| wr_addr | output | ADDR_W | Byte write address |
| wr_data | output | 8 | Byte write data |
| info_valid | output | 1 | Module info pulse |
| info_type | output | 16 | Module type code |
| info_entry | output | 32 | Entry point minus 4 |
| info_persist | output | 32 | Persistent size |
| info_scratch | output | 32 | Scratch size |
| done | output | 1 | Image fully parsed |
| err_code | output | 3 | 0 none, 1 signature, 2 length, 3 block type, 4 zero size |

## Verification
Two things can happen on the same clock edge: the write of a module's last payload byte and the rise of `done`. This occurs when the last module ends exactly at its last payload byte, with no trailing body bytes. The bench provokes it with an image whose final block fills the module, fed with idle gaps on `in_valid`. The scoreboard monitor counts cycles in which `wr_en` and `done` are both high and requires exactly one such cycle, and that write must still match the expected address and data. A second image ends with an empty module, so `done` there must rise with no write beside it.

// File: rtl/fwl_pkg.sv
package fwl_pkg;
   typedef enum logic [2:0] {
      ERR_NONE  = 3'd0,
      ERR_SIG   = 3'd1,
      ERR_LEN   = 3'd2,
      ERR_BTYPE = 3'd3,
      ERR_BZERO = 3'd4
   } fwl_err_e;

   typedef enum logic [2:0] {
      S_IDLE, S_FHDR, S_MHDR, S_BREC, S_PAY, S_SKIP, S_DONE, S_FAIL
   } fwl_state_e;

   localparam logic [31:0] FILE_TAG   = 32'h5453_5324;
   localparam int          FHDR_BYTES = 16;
   localparam logic [31:0] BT_IRAM    = 32'd1;
   localparam logic [31:0] BT_DRAM    = 32'd2;
endpackage

// File: rtl/fwl_le_collect.sv
module fwl_le_collect #(
   parameter int WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take,
   input  logic [7:0]        byte_in,
   output logic [WORD_W-1:0] word_now
);
   logic [WORD_W-1:0] sh;

   // little-endian: newest byte enters at the top
   assign word_now = {byte_in, sh[WORD_W-1:8]};

   always_ff @(posedge clk) begin
      if (!rst_n)    sh <= '0;
      else if (take) sh <= word_now;
   end
endmodule

// File: rtl/fwl_type_filter.sv
module fwl_type_filter #(
   parameter int                   TYPE_W    = 16,
   parameter int                   NUM_CODES = 16,
   parameter logic [NUM_CODES-1:0] ALLOW     = 16'h003F
) (
   input  logic [TYPE_W-1:0] code,
   output logic              ok
);
   logic [NUM_CODES-1:0] hit;

   for (genvar g = 0; g < NUM_CODES; g++) begin : g_cmp
      assign hit[g] = ALLOW[g] && (code == TYPE_W'(g));
   end

   assign ok = |hit;
endmodule

// File: rtl/fwl_addr_gen.sv
module fwl_addr_gen #(
   parameter int              ADDR_W    = 24,
   parameter logic [ADDR_W-1:0] IRAM_BASE = 24'h080000
) (
   input  logic [ADDR_W-1:0] offset,
   input  logic              is_iram,
   output logic [ADDR_W-1:0] addr
);
   if (IRAM_BASE == '0) begin : g_flat
      logic unused_sel;
      assign unused_sel = is_iram;
      assign addr       = offset;
   end else begin : g_based
      assign addr = offset + (is_iram ? IRAM_BASE : '0);
   end
endmodule

// File: rtl/fw_image_loader.sv
module fw_image_loader
   import fwl_pkg::*;
#(
   parameter int                ADDR_W     = 24,
   parameter int                LEN_W      = 32,
   parameter logic [ADDR_W-1:0] IRAM_BASE  = 24'h080000,
   parameter logic [15:0]       ALLOW_MASK = 16'h003F
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [LEN_W-1:0]  total_len,
   input  logic              in_valid,
   input  logic [7:0]        in_byte,
   output logic              in_ready,
   output logic              wr_en,
   output logic              wr_sel,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [7:0]        wr_data,
   output logic              info_valid,
   output logic [15:0]       info_type,
   output logic [31:0]       info_entry,
   output logic [31:0]       info_persist,
   output logic [31:0]       info_scratch,
   output logic              done,
   output logic [2:0]        err_code
);
   localparam int IDX_W = 5;
   localparam int CMP_W = 33;

   if (LEN_W < 8 || LEN_W > 32) begin : g_len_chk
      $error("LEN_W must lie in 8..32");
   end
   if (ADDR_W < 8 || ADDR_W > 32) begin : g_addr_chk
      $error("ADDR_W must lie in 8..32");
   end

   fwl_state_e        state;
   fwl_err_e          err_q;
   logic [IDX_W-1:0]  idx;
   logic [31:0]       mods_left, blocks_left, body_left, pay_left;
   logic [31:0]       mod_entry, mod_persist;
   logic [15:0]       mod_type;
   logic [ADDR_W-1:0] addr_cur, addr_calc;
   logic              sel_cur, type_ok, take;
   logic [31:0]       w, body_dec;

   assign take     = in_valid && in_ready;
   assign err_code = err_q;
   assign body_dec = (body_left != 0) ? body_left - 32'd1 : 32'd0;

   always_comb begin
      in_ready = state inside {S_FHDR, S_MHDR, S_BREC, S_PAY, S_SKIP};
   end

   fwl_le_collect #(.WORD_W(32)) u_col (
      .clk(clk), .rst_n(rst_n), .take(take), .byte_in(in_byte), .word_now(w)
   );

   fwl_type_filter #(.TYPE_W(16), .NUM_CODES(16), .ALLOW(ALLOW_MASK)) u_flt (
      .code(mod_type), .ok(type_ok)
   );

   fwl_addr_gen #(.ADDR_W(ADDR_W), .IRAM_BASE(IRAM_BASE)) u_agen (
      .offset(w[ADDR_W-1:0]), .is_iram(!sel_cur), .addr(addr_calc)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= S_IDLE;  err_q <= ERR_NONE;  idx <= '0;  done <= 1'b0;
         mods_left <= '0;  blocks_left <= '0;  body_left <= '0;  pay_left <= '0;
         mod_entry <= '0;  mod_persist <= '0;  mod_type <= '0;
         addr_cur <= '0;   sel_cur <= 1'b0;
         wr_en <= 1'b0;    wr_sel <= 1'b0;  wr_addr <= '0;  wr_data <= '0;
         info_valid <= 1'b0;  info_type <= '0;  info_entry <= '0;
         info_persist <= '0;  info_scratch <= '0;
      end else begin
         wr_en      <= 1'b0;
         info_valid <= 1'b0;
         if (start) begin
            state <= S_FHDR;  idx <= '0;  err_q <= ERR_NONE;  done <= 1'b0;
         end else if (take) begin
            case (state)
               S_FHDR: begin
                  idx <= idx + 1'b1;
                  if (idx == 5'd3 && w != FILE_TAG) begin
                     state <= S_FAIL;  err_q <= ERR_SIG;
                  end
                  if (idx == 5'd7 &&
                      ({1'b0, w} + CMP_W'(FHDR_BYTES)) != CMP_W'(total_len)) begin
                     state <= S_FAIL;  err_q <= ERR_LEN;
                  end
                  if (idx == 5'd11) mods_left <= w;
                  if (idx == 5'd15) begin
                     idx <= '0;
                     if (mods_left == 0) begin
                        state <= S_DONE;  done <= 1'b1;
                     end else state <= S_MHDR;
                  end
               end
               S_MHDR: begin
                  idx <= idx + 1'b1;
                  case (idx)
                     5'd7:    body_left   <= w;
                     5'd11:   blocks_left <= w;
                     5'd15:   mod_type    <= w[15:0];
                     5'd19:   mod_entry   <= w - 32'd4;
                     5'd23:   mod_persist <= w;
                     default: ;
                  endcase
                  if (idx == 5'd27) begin
                     idx <= '0;
                     if (type_ok) begin
                        info_valid <= 1'b1;  info_type <= mod_type;
                        info_entry <= mod_entry;  info_persist <= mod_persist;
                        info_scratch <= w;
                     end
                     if (type_ok && blocks_left != 0) state <= S_BREC;
                     else if (body_left != 0)         state <= S_SKIP;
                     else begin
                        mods_left <= mods_left - 32'd1;
                        if (mods_left == 32'd1) begin
                           state <= S_DONE;  done <= 1'b1;
                        end else state <= S_MHDR;
                     end
                  end
               end
               S_BREC: begin
                  idx       <= idx + 1'b1;
                  body_left <= body_dec;
                  if (idx == 5'd3) begin
                     if (w != BT_IRAM && w != BT_DRAM) begin
                        state <= S_FAIL;  err_q <= ERR_BTYPE;
                     end
                     sel_cur <= (w == BT_DRAM);
                  end
                  if (idx == 5'd7) begin
                     pay_left <= w;
                     if (w == 0) begin
                        state <= S_FAIL;  err_q <= ERR_BZERO;
                     end
                  end
                  if (idx == 5'd11) addr_cur <= addr_calc;
                  if (idx == 5'd15) begin
                     idx <= '0;  state <= S_PAY;
                  end
               end
               S_PAY: begin
                  wr_en <= 1'b1;  wr_sel <= sel_cur;
                  wr_addr <= addr_cur;  wr_data <= in_byte;
                  addr_cur  <= addr_cur + 1'b1;
                  pay_left  <= pay_left - 32'd1;
                  body_left <= body_dec;
                  if (pay_left == 32'd1) begin
                     blocks_left <= blocks_left - 32'd1;
                     if (blocks_left != 32'd1)  state <= S_BREC;
                     else if (body_dec != 0)    state <= S_SKIP;
                     else begin
                        mods_left <= mods_left - 32'd1;
                        if (mods_left == 32'd1) begin
                           state <= S_DONE;  done <= 1'b1;
                        end else state <= S_MHDR;
                     end
                  end
               end
               S_SKIP: begin
                  body_left <= body_dec;
                  if (body_left <= 32'd1) begin
                     mods_left <= mods_left - 32'd1;
                     if (mods_left == 32'd1) begin
                        state <= S_DONE;  done <= 1'b1;
                     end else state <= S_MHDR;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   // R12
   err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (err_code != 3'd0 && !start) |=> $stable(err_code));

   // R12
   halt_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done || err_code != 3'd0) |-> !in_ready);

   // R6
   no_wr_on_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> err_code == 3'd0);

   // R11
   done_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && err_code != 3'd0));

   // R8
   info_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      info_valid |=> !info_valid);

   // R5
   wr_consec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && $past(wr_en)) |-> wr_addr == $past(wr_addr) + 1'b1);
endmodule

// File: tb/fw_image_loader_test.sv
module fw_image_loader_test;
   logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0, in_valid = 1'b0;
   logic [7:0]  in_byte = '0;
   logic [31:0] total_len = '0;
   logic        in_ready, wr_en, wr_sel, info_valid, done;
   logic [23:0] wr_addr;
   logic [7:0]  wr_data;
   logic [15:0] info_type;
   logic [31:0] info_entry, info_persist, info_scratch;
   logic [2:0]  err_code;

   typedef struct packed {logic sel; logic [23:0] addr; logic [7:0] data;} wr_t;
   typedef struct packed {logic [15:0] typ; logic [31:0] entry, pers, scr;} inf_t;

   int       checks = 0, errors = 0, wr_at_done = 0;
   logic [7:0] img[$];
   wr_t      exp_wr[$];
   inf_t     exp_inf[$];

   always #4 clk = ~clk;

   fw_image_loader uut (
      .clk(clk), .rst_n(rst_n), .start(start), .total_len(total_len),
      .in_valid(in_valid), .in_byte(in_byte), .in_ready(in_ready),
      .wr_en(wr_en), .wr_sel(wr_sel), .wr_addr(wr_addr), .wr_data(wr_data),
      .info_valid(info_valid), .info_type(info_type), .info_entry(info_entry),
      .info_persist(info_persist), .info_scratch(info_scratch),
      .done(done), .err_code(err_code)
   );

   task automatic check(bit ok, string req, string what, longint act, longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic put32(logic [31:0] v);
      for (int k = 0; k < 4; k++) img.push_back(v[8*k +: 8]);
   endtask

   task automatic file_hdr(logic [31:0] tag, logic [31:0] nmod);
      put32(tag); put32(32'h0); put32(nmod); put32(32'd1);
   endtask

   task automatic fix_size();
      logic [31:0] fs = 32'(img.size() - 16);
      for (int k = 0; k < 4; k++) img[4+k] = fs[8*k +: 8];
   endtask

   task automatic mod_hdr(logic [31:0] msize, logic [31:0] nblk, logic [15:0] typ,
                          logic [31:0] entry, logic [31:0] pers, logic [31:0] scr,
                          bit allowed);
      put32(32'h444F_4D24); put32(msize); put32(nblk); put32({16'hBEEF, typ});
      put32(entry); put32(pers); put32(scr);
      if (allowed) exp_inf.push_back({typ, entry - 32'd4, pers, scr});
   endtask

   task automatic blk(logic [31:0] btype, logic [31:0] off, int n, logic [7:0] seed, bit expect_wr);
      put32(btype); put32(32'(n)); put32(off); put32(32'hDEAD_0000);
      for (int k = 0; k < n; k++) begin
         logic [7:0] d;
         d = seed + 8'(k * 7);
         img.push_back(d);
         if (expect_wr)
            exp_wr.push_back({(btype == 32'd2),
                              ((btype == 32'd1) ? 24'h080000 : 24'h0) + off[23:0] + 24'(k), d});
      end
   endtask

   task automatic run(int len_adj, bit gaps, string req, logic [2:0] exp_err, bit exp_done);
      int i = 0;
      int cyc = 0;
      total_len = 32'(img.size() + len_adj);
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      check(err_code == 3'd0 && !done && in_ready, "R1", "start clears status",
            {err_code, done, in_ready}, 3'b001);
      forever begin
         if (i >= img.size() || !in_ready || cyc > 20000) break;
         if (gaps && (cyc % 3 == 1)) in_valid = 1'b0;
         else begin
            in_valid = 1'b1; in_byte = img[i]; i++;
         end
         @(negedge clk); cyc++;
      end
      in_valid = 1'b0;
      repeat (4) @(negedge clk);
      check(err_code == exp_err, req, "error code", err_code, exp_err);
      check(done == exp_done, req, "done", done, exp_done);
      check(!in_ready, "R12", "ready low when finished", in_ready, 0);
      check(exp_wr.size() == 0, "R5", "writes missing", exp_wr.size(), 0);
      check(exp_inf.size() == 0, "R8", "info pulses missing", exp_inf.size(), 0);
      img.delete(); exp_wr.delete(); exp_inf.delete();
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      wr_t  ew;
      inf_t ei;
      if (rst_n && wr_en) begin
         if (done) wr_at_done++;
         if (exp_wr.size() == 0) check(1'b0, "R5", "unexpected write", wr_addr, 0);
         else begin
            ew = exp_wr.pop_front();
            check({wr_sel, wr_addr, wr_data} == ew, "R4", "write sel/addr/data",
                  {wr_sel, wr_addr, wr_data}, ew);
         end
      end
      if (rst_n && info_valid) begin
         if (exp_inf.size() == 0) check(1'b0, "R9", "unexpected info", info_type, 0);
         else begin
            ei = exp_inf.pop_front();
            check({info_type, info_entry, info_persist, info_scratch} == ei, "R8",
                  "module info", info_entry, ei.entry);
         end
      end
   end

   initial begin
      #(8 * 150000);
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(!in_ready && !done && !wr_en && !info_valid && err_code == 3'd0, "R1",
            "reset state", {in_ready, done, wr_en, info_valid, err_code}, 0);

      // R4 R9 R10: allowed module with two blocks and pad, skipped module, empty module
      file_hdr(32'h5453_5324, 32'd3);
      mod_hdr(32'd38, 32'd2, 16'd2, 32'h0000_1004, 32'h200, 32'h80, 1'b1);
      blk(32'd1, 32'h10, 3, 8'h11, 1'b1);
      blk(32'd2, 32'h40, 2, 8'h55, 1'b1);
      img.push_back(8'hEE);
      mod_hdr(32'd5, 32'd1, 16'd9, 32'h44, 32'h1, 32'h2, 1'b0);
      for (int k = 0; k < 5; k++) img.push_back(8'h01);
      mod_hdr(32'd0, 32'd0, 16'd0, 32'h0000_2000, 32'h10, 32'h20, 1'b1);
      fix_size();
      wr_at_done = 0;
      run(0, 1'b0, "R10", 3'd0, 1'b1);
      check(wr_at_done == 0, "R11", "no write beside done after empty module", wr_at_done, 0);

      // R9 boundary type 6 skipped with msize 0, R11 last write with done, gapped input
      file_hdr(32'h5453_5324, 32'd2);
      mod_hdr(32'd0, 32'd3, 16'd6, 32'h8, 32'h9, 32'hA, 1'b0);
      mod_hdr(32'd36, 32'd1, 16'd5, 32'h0000_0104, 32'h7, 32'h3, 1'b1);
      blk(32'd1, 32'h7FF0, 20, 8'hA0, 1'b1);
      fix_size();
      wr_at_done = 0;
      run(0, 1'b1, "R11", 3'd0, 1'b1);
      check(wr_at_done == 1, "R11", "last write with done", wr_at_done, 1);

      // R11 zero modules
      file_hdr(32'h5453_5324, 32'd0);
      fix_size();
      run(0, 1'b0, "R11", 3'd0, 1'b1);

      // R2 bad signature
      file_hdr(32'h5453_5325, 32'd1);
      mod_hdr(32'd18, 32'd1, 16'd1, 32'h10, 32'h1, 32'h1, 1'b0);
      blk(32'd2, 32'h0, 2, 8'h33, 1'b0);
      fix_size();
      run(0, 1'b0, "R2", 3'd1, 1'b0);

      // R3 length mismatch
      file_hdr(32'h5453_5324, 32'd1);
      mod_hdr(32'd18, 32'd1, 16'd1, 32'h10, 32'h1, 32'h1, 1'b0);
      blk(32'd2, 32'h0, 2, 8'h33, 1'b0);
      fix_size();
      run(1, 1'b0, "R3", 3'd2, 1'b0);

      // R6 bad block type after one good block
      file_hdr(32'h5453_5324, 32'd1);
      mod_hdr(32'd36, 32'd2, 16'd1, 32'h30, 32'h4, 32'h5, 1'b1);
      blk(32'd2, 32'h100, 2, 8'h70, 1'b1);
      blk(32'd3, 32'h200, 2, 8'h90, 1'b0);
      fix_size();
      run(0, 1'b0, "R6", 3'd3, 1'b0);

      // R7 zero-size block
      file_hdr(32'h5453_5324, 32'd1);
      mod_hdr(32'd16, 32'd1, 16'd4, 32'h30, 32'h4, 32'h5, 1'b1);
      blk(32'd2, 32'h100, 0, 8'h70, 1'b0);
      fix_size();
      run(0, 1'b0, "R7", 3'd4, 1'b0);

      // R12 error held while idle
      repeat (20) @(negedge clk);
      check(err_code == 3'd4 && !in_ready && !done, "R12", "error held",
            {err_code, in_ready, done}, 3'd4);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule